// File: doc/BRIEF.md
# Bus Transaction Target Decoder

This block chooses which agent claims a bus transaction. Each request carries a 65-bit address. The most significant bit selects the space: 1 means IO space and 0 means memory space. The decoder tries three tiers in order.

- **Programmable windows.** A set of base/limit windows, each enabled separately and each tied to one space. A hit here is a positive decode.
- **Fixed legacy windows.** The display-adapter (VGA) and disk-controller (IDE) legacy ranges. They use the same match logic as the programmable windows but have constant bounds.
- **Subtractive agent.** A single catch-all that claims whatever is still unclaimed, after a deliberate delay.

If the catch-all is absent, the transaction ends in a master abort.

Requests arrive on a valid/ready stream. The decoder works on one transaction at a time. `req_ready` is high only while it is idle, so an upstream source stalls simply by seeing `req_ready` low.

The outcome is offered on a valid/ready result stream. It carries:
- a one-hot target select,
- a claim-kind code,
- an overlap error flag,
- a palette-snoop flag.

The result holds stable until `res_ready` is seen high at a clock edge. Configuration pins are plain levels and are sampled at the acceptance edge.

Top module: `txn_target_decoder`

## Requirements
- R1: A programmable window with its `win_io` bit set matches only requests with address bit 64 = 1. With the bit clear it matches only requests with bit 64 = 0. Legacy VGA and IDE IO ranges also require bit 64 = 1; the VGA memory range requires bit 64 = 0.
- R2: An enabled window i claims when lo_i <= addr[63:0] <= hi_i. Window i drives `res_sel` bit i, with `res_kind` = 1 (fast). `res_valid` rises right after the acceptance edge (latency 1).
- R3: When several windows match, the lowest index wins and `res_overlap` = 1. Otherwise `res_overlap` = 0. `res_sel` is always one-hot or zero.
- R4: VGA legacy ranges are claimed fast on `res_sel` bit NUM_WIN, and only when no programmable window hits. The ranges are IO 0x3B0–0x3BB and 0x3C0–0x3DF, and memory 0xA0000–0xBFFFF.
- R5: IDE legacy IO ranges are claimed fast on `res_sel` bit NUM_WIN+1. The ranges are 0x1F0–0x1F7, 0x3F6, 0x170–0x177 and 0x376. The same offsets in memory space are not claimed by IDE.
- R6: The VGA ranges are claimed only with `vga_hd_en` = 1 and `legacy_fwd_en` = 1. The IDE ranges are claimed only with `ide_hd_en` = 1 and `legacy_fwd_en` = 1. Otherwise the transaction falls to the next tier.
- R7: An unclaimed request with `sub_en` = 1 is claimed on `res_sel` bit NUM_WIN+2, with `res_kind` = 2. `res_valid` rises SUB_DLY edges after acceptance, where the acceptance edge counts as edge 1.
- R8: An unclaimed request with `sub_en` = 0 gives `res_kind` = 3 (master abort) and `res_sel` = 0. The result appears ABORT_DLY edges after acceptance.
- R9: `res_snoop` = 1 exactly when `palette_snoop_en` = 1 and the request is IO space with address 0x3C6–0x3C9. It does not depend on which agent claims.
- R10: While `res_valid` = 1, `req_ready` = 0. While `res_ready` = 0, all result fields stay unchanged. `req_ready` returns to 1 after the edge where `res_valid` and `res_ready` are both 1.
- R11: After reset, `res_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Decoder idle, request taken at the edge |
| req_addr | input | 65 | Bit 64 is the space (1 = IO), bits 63:0 are the address |
| win_en | input | NUM_WIN | Per-window enable |
| win_io | input | NUM_WIN | Per-window space selector |
| win_lo | input | NUM_WIN*64 | Window base addresses, window i at [i*64 +: 64] |
| win_hi | input | NUM_WIN*64 | Window limit addresses (inclusive) |
| legacy_fwd_en | input | 1 | Forward legacy ranges to the legacy agents |
| vga_hd_en | input | 1 | VGA hard-decode enable |
| ide_hd_en | input | 1 | IDE hard-decode enable |
| palette_snoop_en | input | 1 | Palette snoop enable |
| sub_en | input | 1 | Subtractive agent present |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result consumed at the edge |
| res_sel | output | NUM_WIN+3 | One-hot claiming agent |
| res_kind | output | 2 | 1 = fast, 2 = subtractive, 3 = master abort |
| res_overlap | output | 1 | More than one window matched |
| res_snoop | output | 1 | Palette snoop hit |

## Verification
The bench builds the block with NUM_WIN = 4, ADDR_W = 64, SUB_DLY = 3 and ABORT_DLY = 6.

Four windows are enough for two of them to overlap, and for a third to cover VGA IO addresses, so both priority across windows and priority over the legacy tier are exercised. Two of the windows are in each space.

The short delays separate the fast, subtractive and abort latencies by several cycles. This lets every measured latency be told apart from its neighbours.

// File: rtl/tdec_pkg.sv
package tdec_pkg;

  typedef enum logic [1:0] {
    CLAIM_NONE  = 2'd0,
    CLAIM_FAST  = 2'd1,
    CLAIM_SUB   = 2'd2,
    CLAIM_ABORT = 2'd3
  } claim_e;

  // fixed legacy windows: entries below LEG_VGA_N belong to the display agent
  localparam int LEG_N     = 7;
  localparam int LEG_VGA_N = 3;

  localparam logic [63:0] PAL_LO = 64'h3C6;
  localparam logic [63:0] PAL_HI = 64'h3C9;

  function automatic logic [63:0] leg_lo(input int i);
    case (i)
      0:       return 64'h3B0;
      1:       return 64'h3C0;
      2:       return 64'hA0000;
      3:       return 64'h1F0;
      4:       return 64'h3F6;
      5:       return 64'h170;
      6:       return 64'h376;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [63:0] leg_hi(input int i);
    case (i)
      0:       return 64'h3BB;
      1:       return 64'h3DF;
      2:       return 64'hBFFFF;
      3:       return 64'h1F7;
      4:       return 64'h3F6;
      5:       return 64'h177;
      6:       return 64'h376;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic leg_io(input int i);
    return (i != 2);
  endfunction

endpackage

// File: rtl/win_match.sv
module win_match #(
  parameter int AW = 64
) (
  input  logic          en,
  input  logic          io,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW:0]   addr,
  output logic          hit
);
  logic space_ok;
  logic range_ok;

  always_comb begin
    space_ok = (addr[AW] == io);
    range_ok = (addr[AW-1:0] >= lo) && (addr[AW-1:0] <= hi);
    hit      = en && space_ok && range_ok;
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] pick,
  output logic         any,
  output logic         multi
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) pick = N'(1) << i;
    end
    any   = |hits;
    multi = ($countones(hits) > 1);
  end
endmodule

// File: rtl/claim_seq.sv
module claim_seq
  import tdec_pkg::*;
#(
  parameter int NT        = 7,
  parameter int SUB_DLY   = 3,
  parameter int ABORT_DLY = 6,
  localparam int CW       = $clog2(ABORT_DLY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          fast_hit,
  input  logic [NT-1:0] fast_sel,
  input  logic          overlap,
  input  logic          snoop,
  input  logic          sub_en,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [NT-1:0] res_sel,
  output logic [1:0]    res_kind,
  output logic          res_overlap,
  output logic          res_snoop
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_OUT} st_e;

  st_e           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          accept;

  assign req_ready = (st == ST_IDLE);
  assign res_valid = (st == ST_OUT);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      lim         <= '0;
      res_sel     <= '0;
      res_kind    <= CLAIM_NONE;
      res_overlap <= 1'b0;
      res_snoop   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          res_overlap <= overlap;
          res_snoop   <= snoop;
          cnt         <= CW'(1);
          if (fast_hit) begin
            res_sel  <= fast_sel;
            res_kind <= CLAIM_FAST;
            st       <= ST_OUT;
          end else if (sub_en) begin
            res_sel  <= NT'(1) << (NT - 1);
            res_kind <= CLAIM_SUB;
            lim      <= CW'(SUB_DLY - 1);
            st       <= ST_WAIT;
          end else begin
            res_sel  <= '0;
            res_kind <= CLAIM_ABORT;
            lim      <= CW'(ABORT_DLY - 1);
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (cnt == lim) st <= ST_OUT;
          else            cnt <= cnt + CW'(1);
        end
        ST_OUT: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_sel) && $stable(res_kind)
      && $stable(res_overlap) && $stable(res_snoop)); // R10
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready); // R10
  AST_FAST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fast_hit |=> res_valid && res_kind == CLAIM_FAST); // R2
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(res_sel)); // R3
  AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == CLAIM_ABORT |-> res_sel == '0); // R8
  AST_SUB_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_kind == CLAIM_SUB |-> res_sel[NT-1] && $countones(res_sel) == 1); // R7
  AST_SUB_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !fast_hit |=> !res_valid); // R7
endmodule

// File: rtl/txn_target_decoder.sv
module txn_target_decoder
  import tdec_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int ADDR_W    = 64,
  parameter int SUB_DLY   = 3,
  parameter int ABORT_DLY = 6,
  localparam int NT       = NUM_WIN + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W:0]         req_addr,
  input  logic [NUM_WIN-1:0]      win_en,
  input  logic [NUM_WIN-1:0]      win_io,
  input  logic [NUM_WIN*ADDR_W-1:0] win_lo,
  input  logic [NUM_WIN*ADDR_W-1:0] win_hi,
  input  logic                    legacy_fwd_en,
  input  logic                    vga_hd_en,
  input  logic                    ide_hd_en,
  input  logic                    palette_snoop_en,
  input  logic                    sub_en,
  output logic                    res_valid,
  input  logic                    res_ready,
  output logic [NT-1:0]           res_sel,
  output logic [1:0]              res_kind,
  output logic                    res_overlap,
  output logic                    res_snoop
);
  logic [NUM_WIN-1:0] win_hit;
  logic [NUM_WIN-1:0] win_pick;
  logic               win_any;
  logic               win_multi;
  logic [LEG_N-1:0]   leg_hit;
  logic               vga_claim;
  logic               ide_claim;
  logic               pal_hit;
  logic               fast_hit;
  logic [NT-1:0]      fast_sel;

  // tier 1: programmable windows
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    win_match #(.AW(ADDR_W)) u_m (
      .en  (win_en[i]),
      .io  (win_io[i]),
      .lo  (win_lo[i*ADDR_W +: ADDR_W]),
      .hi  (win_hi[i*ADDR_W +: ADDR_W]),
      .addr(req_addr),
      .hit (win_hit[i])
    );
  end

  prio_pick #(.N(NUM_WIN)) u_pick (
    .hits (win_hit),
    .pick (win_pick),
    .any  (win_any),
    .multi(win_multi)
  );

  // tier 2: fixed legacy windows, same comparator with constant bounds
  for (genvar j = 0; j < LEG_N; j++) begin : g_leg
    win_match #(.AW(ADDR_W)) u_m (
      .en  (1'b1),
      .io  (leg_io(j)),
      .lo  (ADDR_W'(leg_lo(j))),
      .hi  (ADDR_W'(leg_hi(j))),
      .addr(req_addr),
      .hit (leg_hit[j])
    );
  end

  win_match #(.AW(ADDR_W)) u_pal (
    .en  (palette_snoop_en),
    .io  (1'b1),
    .lo  (ADDR_W'(PAL_LO)),
    .hi  (ADDR_W'(PAL_HI)),
    .addr(req_addr),
    .hit (pal_hit)
  );

  always_comb begin
    vga_claim = legacy_fwd_en && vga_hd_en && (|leg_hit[LEG_VGA_N-1:0]);
    ide_claim = legacy_fwd_en && ide_hd_en && (|leg_hit[LEG_N-1:LEG_VGA_N]);
    fast_sel  = '0;
    if (win_any)        fast_sel[NUM_WIN-1:0] = win_pick;
    else if (vga_claim) fast_sel[NUM_WIN]     = 1'b1;
    else if (ide_claim) fast_sel[NUM_WIN+1]   = 1'b1;
    fast_hit = win_any || vga_claim || ide_claim;
  end

  claim_seq #(.NT(NT), .SUB_DLY(SUB_DLY), .ABORT_DLY(ABORT_DLY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .fast_hit   (fast_hit),
    .fast_sel   (fast_sel),
    .overlap    (win_multi),
    .snoop      (pal_hit),
    .sub_en     (sub_en),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_sel    (res_sel),
    .res_kind   (res_kind),
    .res_overlap(res_overlap),
    .res_snoop  (res_snoop)
  );

  AST_LEGACY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !legacy_fwd_en && !win_any |-> !fast_hit); // R6
  AST_WIN_BEATS_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && win_any |=> res_sel[NT-1:NUM_WIN] == '0); // R4
  AST_OVERLAP_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && win_hit[0] |=> res_sel[0]); // R3
endmodule

// File: tb/txn_target_decoder_tb.sv
module txn_target_decoder_tb;
  localparam int NW = 4;
  localparam int AW = 64;
  localparam int SD = 3;
  localparam int AD = 6;
  localparam int NT = NW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW:0] req_addr = '0;
  logic [NW-1:0] win_en = '0, win_io = '0;
  logic [NW*AW-1:0] win_lo = '0, win_hi = '0;
  logic legacy_fwd_en = 1'b1, vga_hd_en = 1'b1, ide_hd_en = 1'b1;
  logic palette_snoop_en = 1'b0, sub_en = 1'b1;
  logic res_valid, res_ready = 1'b0;
  logic [NT-1:0] res_sel;
  logic [1:0] res_kind;
  logic res_overlap, res_snoop;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txn_target_decoder #(.NUM_WIN(NW), .ADDR_W(AW), .SUB_DLY(SD), .ABORT_DLY(AD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .win_en(win_en), .win_io(win_io), .win_lo(win_lo),
    .win_hi(win_hi), .legacy_fwd_en(legacy_fwd_en), .vga_hd_en(vga_hd_en),
    .ide_hd_en(ide_hd_en), .palette_snoop_en(palette_snoop_en), .sub_en(sub_en),
    .res_valid(res_valid), .res_ready(res_ready), .res_sel(res_sel),
    .res_kind(res_kind), .res_overlap(res_overlap), .res_snoop(res_snoop)
  );

  function automatic logic [63:0] wlo(input int i);
    case (i) 0: return 64'h1000_0000; 1: return 64'h1000_8000;
             2: return 64'h1000;      default: return 64'h3C0; endcase
  endfunction
  function automatic logic [63:0] whi(input int i);
    case (i) 0: return 64'h1000_FFFF; 1: return 64'h1001_7FFF;
             2: return 64'h10FF;      default: return 64'h3C3; endcase
  endfunction
  function automatic logic wio(input int i);
    return (i >= 2);
  endfunction

  function automatic bit inr(input logic [63:0] a, input logic [63:0] lo, input logic [63:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic model(input logic [AW:0] a, output logic [NT-1:0] sel,
                       output logic [1:0] kind, output logic ovl, output logic snp,
                       output int lat);
    int nhit;
    logic io;
    logic [63:0] x;
    bit vga, ide;
    io = a[AW];
    x = a[63:0];
    nhit = 0;
    sel = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (win_en[i] && io == wio(i) && inr(x, wlo(i), whi(i))) begin
        nhit++;
        sel = '0;
        sel[i] = 1'b1;
      end
    end
    ovl = (nhit > 1);
    snp = palette_snoop_en && io && inr(x, 64'h3C6, 64'h3C9);
    vga = io ? (inr(x, 64'h3B0, 64'h3BB) || inr(x, 64'h3C0, 64'h3DF))
             : inr(x, 64'hA0000, 64'hBFFFF);
    ide = io && (inr(x, 64'h1F0, 64'h1F7) || x == 64'h3F6 ||
                 inr(x, 64'h170, 64'h177) || x == 64'h376);
    vga = vga && vga_hd_en && legacy_fwd_en;
    ide = ide && ide_hd_en && legacy_fwd_en;
    if (nhit > 0) begin kind = 2'd1; lat = 1; end
    else if (vga) begin sel[NW] = 1'b1; kind = 2'd1; lat = 1; end
    else if (ide) begin sel[NW+1] = 1'b1; kind = 2'd1; lat = 1; end
    else if (sub_en) begin sel[NW+2] = 1'b1; kind = 2'd2; lat = SD; end
    else begin kind = 2'd3; lat = AD; end
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one transaction; hold cycles with res_ready low before consuming
  task automatic run(input logic [AW:0] a, input string req, input int hold);
    logic [NT-1:0] es;
    logic [1:0] ek;
    logic eo, ep;
    int el, lat;
    logic [NT-1:0] s0;
    model(a, es, ek, eo, ep, el);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "latency", 64'(lat), 64'(el));
    chk(req, "sel", 64'(res_sel), 64'(es));
    chk(req, "kind", 64'(res_kind), 64'(ek));
    chk("R3", "overlap", 64'(res_overlap), 64'(eo));
    chk("R9", "snoop", 64'(res_snoop), 64'(ep));
    chk("R10", "ready while result", 64'(req_ready), 64'(0));
    s0 = res_sel;
    for (int k = 0; k < hold; k++) @(negedge clk);
    chk("R10", "held sel", 64'({res_valid, res_sel}), 64'({1'b1, s0}));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk("R10", "ready after handshake", 64'({req_ready, res_valid}), 64'(2'b10));
  endtask

  function automatic logic [AW:0] pick_addr(input int r);
    logic [63:0] off;
    off = 64'($urandom_range(0, 31));
    case (r % 10)
      0: return {1'b0, 64'h1000_7FF0 + off * 64'h40};
      1: return {1'b1, 64'h1000 + off * 64'd9};
      2: return {1'b1, 64'h3B0 + off * 64'd2};
      3: return {1'b1, 64'h3C0 + off};
      4: return {1'b0, 64'h9FFF0 + off * 64'h1000};
      5: return {1'b1, 64'h1F0 + off};
      6: return {1'b1, 64'h370 + off / 4};
      7: return {1'b0, 64'h1F0 + off};
      8: return {1'b1, 64'h160 + off};
      default: return {$urandom_range(0, 1) == 1, 32'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NW; i++) begin
      win_lo[i*AW +: AW] = wlo(i);
      win_hi[i*AW +: AW] = whi(i);
      win_io[i] = wio(i);
    end
    win_en = '1;
    repeat (3) @(negedge clk);
    chk("R11", "reset state", 64'({req_ready, res_valid}), 64'(2'b10));
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run({1'b0, 64'h1000_0000}, "R2", 0);
    run({1'b0, 64'h1000_FFFF}, "R2", 2);
    run({1'b0, 64'h1000_9000}, "R3", 0);          // windows 0 and 1 overlap
    run({1'b1, 64'h1000_9000}, "R1", 0);          // memory window, IO request
    run({1'b0, 64'h1050}, "R1", 0);               // IO window, memory request
    run({1'b1, 64'h3C1}, "R4", 0);                // window 3 beats VGA
    run({1'b1, 64'h3C4}, "R4", 1);
    run({1'b0, 64'hA0000}, "R4", 0);
    run({1'b0, 64'hBFFFF}, "R4", 0);
    run({1'b1, 64'h3F6}, "R5", 0);
    run({1'b1, 64'h377}, "R7", 0);                // just past IDE single port
    run({1'b0, 64'h376}, "R5", 0);                // IDE offset in memory space
    palette_snoop_en = 1'b1;
    run({1'b1, 64'h3C6}, "R9", 0);
    run({1'b1, 64'h3C9}, "R9", 0);
    run({1'b0, 64'h3C8}, "R9", 0);
    legacy_fwd_en = 1'b0;
    run({1'b1, 64'h3B5}, "R6", 0);
    run({1'b1, 64'h1F2}, "R6", 0);
    legacy_fwd_en = 1'b1;
    vga_hd_en = 1'b0;
    run({1'b0, 64'hB8000}, "R6", 0);
    vga_hd_en = 1'b1;
    ide_hd_en = 1'b0;
    run({1'b1, 64'h170}, "R6", 0);
    ide_hd_en = 1'b1;
    sub_en = 1'b0;
    run({1'b1, 64'h9000}, "R8", 3);
    sub_en = 1'b1;
    run({1'b1, 64'h9000}, "R7", 2);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) begin
        legacy_fwd_en    = ($urandom_range(0, 3) != 0);
        vga_hd_en        = ($urandom_range(0, 3) != 0);
        ide_hd_en        = ($urandom_range(0, 3) != 0);
        palette_snoop_en = $urandom_range(0, 1) == 1;
        sub_en           = ($urandom_range(0, 2) != 0);
        win_en           = NW'($urandom);
      end
      run(pick_addr(int'($urandom_range(0, 9))), "R2", int'($urandom_range(0, 2)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule